// File: doc/BRIEF.md
# Audio Sample Unpacker with Channel Distribution

This block fetches packed audio samples from memory, one 32-bit word at a time, and spreads them over up to four output pairs. Each pair has a left and a right 16-bit slot. Samples are stored as 16 or 32 bits each. In stereo mode each sample fills its own slot. In mono mode one sample feeds both slots of a pair. Software chooses the number of active pairs, the byte order and an optional inversion of the sample MSB. That inversion turns offset-binary samples into two's complement.

Memory is read in sequence through a simple request/valid port, with one read outstanding at a time. Two buffers of equal size are used in turn. Each buffer has its own base address. When the last word of a buffer has been requested, the block marks that buffer finished and moves on to the other buffer. If software has not handed that other buffer over in time, the block raises a sticky underrun flag.

A frame strobe from the serial side picks up one complete set of slot values. If the set is not yet complete when the strobe arrives, every slot carries silence instead.

Top module: `pcm_unpacker`

## Requirements
- R1: After `run_en` rises, the first read address is `base0`. Each later read is 4 bytes above the previous one within a buffer. `rd_req` is a one-cycle pulse, and no new request is issued until `rd_valid` has returned the previous word.
- R2: In 16-bit mode (`cfg_wide`=0) a word holds two samples, and the sample at the lower byte address is used first. In 32-bit mode (`cfg_wide`=1) a word holds one sample, and only its upper 16 bits reach the slot. Byte k of a word (address offset k) is `rd_data[8k+7:8k]`.
- R3: When `cfg_little`=1, the byte at the lower address is the less significant byte of a sample. When `cfg_little`=0, it is the more significant byte.
- R4: When `cfg_sign_inv`=1, bit 15 of every sample is inverted, and the silence value becomes 16'h8000. Otherwise silence is 16'h0000.
- R5: `cfg_pairs`+1 pairs are active. Slot j sits at `slot_data[16j+15:16j]`, with pair j/2 and side j%2 (0 is left). In stereo mode (`cfg_stereo`=1), sample i of a set goes to slot i.
- R6: In mono mode (`cfg_stereo`=0), sample i of a set goes to both slots of pair i.
- R7: The slots of inactive pairs carry the silence value.
- R8: When `frame_tick` is high and a full set is staged, `slot_data` shows that set on the next cycle and `frame_ok` is 1. The following set continues the sample stream without gaps. `slot_data` changes only after a tick.
- R9: When `frame_tick` is high and the set is incomplete, every slot carries silence and `frame_ok` is 0. The samples staged so far are kept for the next tick.
- R10: After the last word of a buffer (offset + 4 ≥ `buf_size`) has been requested, the next address is the base of the other buffer. Buffer 0 comes first.
- R11: `buf_done[i]` is set when buffer i is finished and stays set until a pulse on `buf_ack[i]`. That pulse also marks buffer i as ready.
- R12: `underrun` is set when the block switches into a buffer that has not been marked ready. It stays set until `run_en` is low.
- R13: After reset, `rd_req`, `slot_data`, `frame_ok`, `buf_done` and `underrun` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Run; low rewinds to buffer 0 and clears staging |
| cfg_wide | input | 1 | 1: 32-bit samples, 0: 16-bit samples |
| cfg_stereo | input | 1 | 1: stereo, 0: mono |
| cfg_pairs | input | 2 | Active pairs minus one |
| cfg_little | input | 1 | Byte order of samples |
| cfg_sign_inv | input | 1 | Invert sample MSB |
| base0 | input | ADDR_W | Byte base of buffer 0 |
| base1 | input | ADDR_W | Byte base of buffer 1 |
| buf_size | input | SIZE_W | Shared buffer size in bytes, multiple of 4 |
| buf_ack | input | 2 | Per-buffer ready pulse from software |
| rd_req | output | 1 | Read request pulse |
| rd_addr | output | ADDR_W | Byte address of the word read |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data word |
| frame_tick | input | 1 | Frame strobe from the serial side |
| slot_data | output | 128 | Eight 16-bit slot values |
| frame_ok | output | 1 | Last tick delivered a full set |
| buf_done | output | 2 | Sticky per-buffer finished flags |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The bench builds the block with its default 32-bit address and 16-bit size widths, and uses small buffer sizes at run time. Its table walks eight mode combinations over two consecutive frames each. These include the odd set sizes in 16-bit mono, where one word straddles two sets, and partial pair counts where silence must appear. An 8-byte buffer size makes both buffer switches happen within a handful of words, so alternation, the done flags and underrun can be checked directly. An early tick reaches the silence-substitution path.

// File: rtl/pcm_pkg.sv
// Shared constants and the sample extraction function for the unpacker.
// Assumes 32-bit memory words and 16-bit output slots.
package pcm_pkg;
    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int SAMPLE_W   = 16;
    localparam int NUM_PAIRS  = 4;
    localparam int NUM_SLOTS  = 2 * NUM_PAIRS;
    localparam int CNT_W      = $clog2(NUM_SLOTS + 1);

    typedef struct packed {
        logic       wide;
        logic       stereo;
        logic [1:0] pairs;
        logic       little;
        logic       sign_inv;
    } pcm_mode_t;

    // Build one 16-bit slot sample from a word; half selects the upper address half.
    function automatic logic [SAMPLE_W-1:0] pick_sample(
        input logic [WORD_W-1:0] w,
        input logic              half,
        input pcm_mode_t         m
    );
        logic [SAMPLE_W-1:0] s;
        if (m.wide)
            s = m.little ? {w[31:24], w[23:16]} : {w[7:0], w[15:8]};
        else if (!half)
            s = m.little ? {w[15:8], w[7:0]} : {w[7:0], w[15:8]};
        else
            s = m.little ? {w[31:24], w[23:16]} : {w[23:16], w[31:24]};
        return s ^ {m.sign_inv, {(SAMPLE_W-1){1'b0}}};
    endfunction
endpackage

// File: rtl/pcm_fetch.sv
// Read address generator with two alternating buffers.
// Issues one request at a time when the unpacker holds no word.
// Tracks per-buffer ready/done state and the underrun flag.
// Assumes buf_size is a nonzero multiple of the word size and that bases
// and size stay fixed while run_en is high.
module pcm_fetch #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              want,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] base0,
    input  logic [ADDR_W-1:0] base1,
    input  logic [SIZE_W-1:0] buf_size,
    input  logic [1:0]        buf_ack,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [1:0]        buf_done,
    output logic              underrun
);
    import pcm_pkg::*;

    localparam logic [SIZE_W:0] STEP = (SIZE_W+1)'(WORD_BYTES);

    logic [SIZE_W-1:0] offset;
    logic              cur;
    logic              nxt;
    logic              pending;
    logic [1:0]        ready;
    logic [SIZE_W:0]   next_off;
    logic              last;
    logic              issue;
    logic [ADDR_W-1:0] base_cur;

    assign nxt      = !cur;
    assign next_off = {1'b0, offset} + STEP;
    assign last     = next_off >= {1'b0, buf_size};
    assign issue    = run_en && want && !pending;
    assign base_cur = cur ? base1 : base0;

    // Track the single outstanding read.
    always_ff @(posedge clk) begin
        if (!rst_n)        pending <= 1'b0;
        else if (issue)    pending <= 1'b1;
        else if (rd_valid) pending <= 1'b0;
    end

    // Register the request pulse and its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_req  <= 1'b0;
            rd_addr <= '0;
        end else begin
            rd_req <= issue;
            if (issue) rd_addr <= base_cur + ADDR_W'(offset);
        end
    end

    // Advance the offset and switch buffers at the end of one.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            offset <= '0;
            cur    <= 1'b0;
        end else if (issue) begin
            if (last) begin
                offset <= '0;
                cur    <= nxt;
            end else begin
                offset <= next_off[SIZE_W-1:0];
            end
        end
    end

    // Maintain ready, done and underrun state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready    <= 2'b00;
            buf_done <= 2'b00;
            underrun <= 1'b0;
        end else begin
            for (int i = 0; i < 2; i++) begin
                if (buf_ack[i]) begin
                    ready[i]    <= 1'b1;
                    buf_done[i] <= 1'b0;
                end
            end
            if (issue && last) begin
                buf_done[cur] <= 1'b1;
                ready[cur]    <= 1'b0;
                if (!ready[nxt] && !buf_ack[nxt]) underrun <= 1'b1;
            end
            if (!run_en) underrun <= 1'b0;
        end
    end

    AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req); // R1
    AST_ADDR_IN_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (((rd_addr - base0) < ADDR_W'(buf_size)) ||
                    ((rd_addr - base1) < ADDR_W'(buf_size)))); // R10
    AST_DONE0_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_done[0]) |-> $past(buf_ack[0])); // R11
    AST_DONE1_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_done[1]) |-> $past(buf_ack[1])); // R11
    AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && run_en) |=> underrun); // R12
endmodule

// File: rtl/pcm_unpack.sv
// Holds the current memory word, cuts it into samples and writes them in
// order into the staging slots. In stereo mode it fills one slot per
// sample; in mono mode it fills both slots of a pair.
// Assumes the mode is held steady while run_en is high.
module pcm_unpack (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        run_en,
    input  pcm_pkg::pcm_mode_t                          mode,
    input  logic                                        rd_valid,
    input  logic [pcm_pkg::WORD_W-1:0]                  rd_data,
    input  logic                                        take_set,
    output logic                                        word_empty,
    output logic [pcm_pkg::NUM_SLOTS*pcm_pkg::SAMPLE_W-1:0] stage,
    output logic                                        complete
);
    import pcm_pkg::*;

    logic [WORD_W-1:0]   word;
    logic                wvalid;
    logic                half;
    logic [CNT_W-1:0]    cnt;
    logic [CNT_W-1:0]    pairs_n;
    logic [CNT_W-1:0]    need;
    logic                full;
    logic                adv;
    logic [SAMPLE_W-1:0] cur_sample;

    assign pairs_n    = CNT_W'(mode.pairs) + CNT_W'(1);
    assign need       = mode.stereo ? (pairs_n << 1) : pairs_n;
    assign full       = (cnt == need);
    assign complete   = full;
    assign word_empty = !wvalid;
    assign adv        = run_en && wvalid && !full && !take_set;
    assign cur_sample = pick_sample(word, half, mode);

    // Load a returned word and step through its samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word   <= '0;
            wvalid <= 1'b0;
            half   <= 1'b0;
        end else if (!run_en) begin
            wvalid <= 1'b0;
            half   <= 1'b0;
        end else if (rd_valid && !wvalid) begin
            word   <= rd_data;
            wvalid <= 1'b1;
            half   <= 1'b0;
        end else if (adv) begin
            if (mode.wide || half) begin
                wvalid <= 1'b0;
                half   <= 1'b0;
            end else begin
                half <= 1'b1;
            end
        end
    end

    // Count samples staged for the current set.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) cnt <= '0;
        else if (take_set)     cnt <= '0;
        else if (adv)          cnt <= cnt + CNT_W'(1);
    end

    for (genvar j = 0; j < NUM_SLOTS; j++) begin : g_slot
        logic                we;
        logic [SAMPLE_W-1:0] q;
        assign we = adv && (mode.stereo ? (cnt == CNT_W'(j)) : (cnt == CNT_W'(j/2)));
        // Capture the current sample into this staging slot.
        always_ff @(posedge clk) begin
            if (!rst_n)  q <= '0;
            else if (we) q <= cur_sample;
        end
        assign stage[j*SAMPLE_W +: SAMPLE_W] = q;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n || !run_en)
        cnt <= need); // R5
    AST_WORD_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !wvalid); // R1
endmodule

// File: rtl/pcm_slot_out.sv
// Output slot register. On a frame tick it shows the staged set, with
// silence in inactive pairs, or silence in every slot when the set is
// incomplete.
module pcm_slot_out (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        tick,
    input  logic                                        complete,
    input  logic [1:0]                                  pairs,
    input  logic                                        sign_inv,
    input  logic [pcm_pkg::NUM_SLOTS*pcm_pkg::SAMPLE_W-1:0] stage,
    output logic [pcm_pkg::NUM_SLOTS*pcm_pkg::SAMPLE_W-1:0] slot_data,
    output logic                                        frame_ok
);
    import pcm_pkg::*;

    logic [SAMPLE_W-1:0] silence;
    assign silence = {sign_inv, {(SAMPLE_W-1){1'b0}}};

    for (genvar j = 0; j < NUM_SLOTS; j++) begin : g_out
        logic active;
        assign active = (2'(j/2) <= pairs);
        // Update this slot once per frame tick.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_data[j*SAMPLE_W +: SAMPLE_W] <= '0;
            else if (tick)
                slot_data[j*SAMPLE_W +: SAMPLE_W] <=
                    (complete && active) ? stage[j*SAMPLE_W +: SAMPLE_W] : silence;
        end
    end

    // Report whether the last tick found a full set.
    always_ff @(posedge clk) begin
        if (!rst_n)    frame_ok <= 1'b0;
        else if (tick) frame_ok <= complete;
    end

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(slot_data)); // R8
    AST_OK_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_ok) |-> $past(tick)); // R8
endmodule

// File: rtl/pcm_unpacker.sv
// Top level: read address generation, word unpacking into staging slots,
// and the frame-synchronous output register.
module pcm_unpacker #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          cfg_wide,
    input  logic          cfg_stereo,
    input  logic [1:0]    cfg_pairs,
    input  logic          cfg_little,
    input  logic          cfg_sign_inv,
    input  logic [ADDR_W-1:0] base0,
    input  logic [ADDR_W-1:0] base1,
    input  logic [SIZE_W-1:0] buf_size,
    input  logic [1:0]    buf_ack,
    output logic          rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic          rd_valid,
    input  logic [31:0]   rd_data,
    input  logic          frame_tick,
    output logic [127:0]  slot_data,
    output logic          frame_ok,
    output logic [1:0]    buf_done,
    output logic          underrun
);
    import pcm_pkg::*;

    pcm_mode_t                      mode;
    logic                           word_empty;
    logic                           complete;
    logic                           take_set;
    logic [NUM_SLOTS*SAMPLE_W-1:0]  stage;

    assign mode     = '{wide: cfg_wide, stereo: cfg_stereo, pairs: cfg_pairs,
                        little: cfg_little, sign_inv: cfg_sign_inv};
    assign take_set = frame_tick && complete;

    pcm_fetch #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) i_fetch (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .want(word_empty),
        .rd_valid(rd_valid), .base0(base0), .base1(base1), .buf_size(buf_size),
        .buf_ack(buf_ack), .rd_req(rd_req), .rd_addr(rd_addr),
        .buf_done(buf_done), .underrun(underrun)
    );

    pcm_unpack i_unpack (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode(mode),
        .rd_valid(rd_valid), .rd_data(rd_data), .take_set(take_set),
        .word_empty(word_empty), .stage(stage), .complete(complete)
    );

    pcm_slot_out i_out (
        .clk(clk), .rst_n(rst_n), .tick(frame_tick), .complete(complete),
        .pairs(cfg_pairs), .sign_inv(cfg_sign_inv), .stage(stage),
        .slot_data(slot_data), .frame_ok(frame_ok)
    );
endmodule

// File: tb/test_pcm_unpacker.sv
`timescale 1ns/1ps
module test_pcm_unpacker;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         run_en = 1'b0;
    logic         cfg_wide = 1'b0, cfg_stereo = 1'b1, cfg_little = 1'b1, cfg_sign_inv = 1'b0;
    logic [1:0]   cfg_pairs = 2'd3;
    logic [31:0]  base0 = 32'h1000, base1 = 32'h2000;
    logic [15:0]  buf_size = 16'h0100;
    logic [1:0]   buf_ack = 2'b00;
    logic         rd_req;
    logic [31:0]  rd_addr;
    logic         rd_valid = 1'b0;
    logic [31:0]  rd_data = '0;
    logic         frame_tick = 1'b0;
    logic [127:0] slot_data;
    logic         frame_ok;
    logic [1:0]   buf_done;
    logic         underrun;

    int checks = 0;
    int fails  = 0;
    logic        log_clr = 1'b0;
    int          nreq = 0;
    logic [31:0] log_addr [8];

    always #2.5 clk = ~clk;

    pcm_unpacker i_pcm_unpacker (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_wide(cfg_wide),
        .cfg_stereo(cfg_stereo), .cfg_pairs(cfg_pairs), .cfg_little(cfg_little),
        .cfg_sign_inv(cfg_sign_inv), .base0(base0), .base1(base1),
        .buf_size(buf_size), .buf_ack(buf_ack), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .frame_tick(frame_tick),
        .slot_data(slot_data), .frame_ok(frame_ok), .buf_done(buf_done),
        .underrun(underrun)
    );

    function automatic logic [7:0] mbyte(input logic [31:0] a);
        return a[7:0] * 8'd7 + 8'd3;
    endfunction

    // Memory model: answers each request one cycle later.
    always @(posedge clk) begin
        rd_valid <= rd_req;
        rd_data  <= {mbyte(rd_addr + 3), mbyte(rd_addr + 2), mbyte(rd_addr + 1), mbyte(rd_addr)};
    end

    // Request log for address checks.
    always @(posedge clk) begin
        if (log_clr) nreq <= 0;
        else if (rd_req) begin
            if (nreq < 8) log_addr[nreq[2:0]] <= rd_addr;
            nreq <= nreq + 1;
        end
    end

    // cfg: [5] wide, [4] stereo, [3:2] pairs-1, [1] little, [0] inv
    function automatic logic [15:0] exp_at(input logic [31:0] a, input logic [5:0] cfg);
        logic [15:0] s;
        if (cfg[5]) s = cfg[1] ? {mbyte(a + 3), mbyte(a + 2)} : {mbyte(a), mbyte(a + 1)};
        else        s = cfg[1] ? {mbyte(a + 1), mbyte(a)}     : {mbyte(a), mbyte(a + 1)};
        return s ^ {cfg[0], 15'b0};
    endfunction

    function automatic logic [127:0] exp_set(input logic [31:0] base, input int k,
                                             input logic [5:0] cfg, input int n);
        logic [127:0] v;
        for (int j = 0; j < 8; j++) begin
            int idx;
            if ((j / 2) > int'(cfg[3:2])) v[16*j +: 16] = {cfg[0], 15'b0};
            else begin
                idx = k * n + (cfg[4] ? j : j / 2);
                v[16*j +: 16] = exp_at(base + (cfg[5] ? 4 * idx : 2 * idx), cfg);
            end
        end
        return v;
    endfunction

    task automatic check(input string req, input logic [159:0] act, input logic [159:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
    endtask

    task automatic apply(input logic [5:0] cfg);
        {cfg_wide, cfg_stereo, cfg_pairs, cfg_little, cfg_sign_inv} = cfg;
    endtask

    // Stimulus table: {cfg, samples per set}
    localparam logic [9:0] VEC [8] = '{
        {6'b0_1_11_1_0, 4'd8},  // 16-bit stereo 4 pairs, little
        {6'b0_1_00_0_0, 4'd2},  // 16-bit stereo 1 pair, big
        {6'b0_0_10_1_1, 4'd3},  // 16-bit mono 3 pairs, inverted, odd set
        {6'b1_1_01_1_0, 4'd4},  // 32-bit stereo 2 pairs, little
        {6'b1_0_11_0_1, 4'd4},  // 32-bit mono 4 pairs, big, inverted
        {6'b0_0_00_0_0, 4'd1},  // 16-bit mono 1 pair
        {6'b1_1_11_0_0, 4'd8},  // 32-bit stereo 4 pairs, big
        {6'b0_1_10_1_1, 4'd6}   // 16-bit stereo 3 pairs, inverted
    };

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13: reset state
        check("R13 reset", {123'b0, rd_req, frame_ok, buf_done, underrun}, 160'b0);
        check("R13 reset slots", {32'b0, slot_data}, 160'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table: two consecutive sets per mode
        for (int r = 0; r < 8; r++) begin
            run_en = 1'b0;
            apply(VEC[r][9:4]);
            base0 = 32'h1000; base1 = 32'h2000; buf_size = 16'h0100;
            repeat (2) @(negedge clk);
            run_en = 1'b1;
            repeat (80) @(negedge clk);
            tick();
            check("R2 R3 R4 R5 R6 R7 R8 set0", {31'b0, frame_ok, slot_data},
                  {31'b0, 1'b1, exp_set(32'h1000, 0, VEC[r][9:4], int'(VEC[r][3:0]))});
            repeat (80) @(negedge clk);
            tick();
            check("R2 R3 R5 R6 R8 set1", {31'b0, frame_ok, slot_data},
                  {31'b0, 1'b1, exp_set(32'h1000, 1, VEC[r][9:4], int'(VEC[r][3:0]))});
        end

        // R9: early tick gives silence, staged samples survive
        run_en = 1'b0;
        apply(6'b0_1_11_1_1);
        repeat (2) @(negedge clk);
        run_en = 1'b1;
        repeat (2) @(negedge clk);
        tick();
        check("R9 early tick", {31'b0, frame_ok, slot_data}, {31'b0, 1'b0, {8{16'h8000}}});
        repeat (80) @(negedge clk);
        tick();
        check("R9 kept set", {31'b0, frame_ok, slot_data},
              {31'b0, 1'b1, exp_set(32'h1000, 0, 6'b0_1_11_1_1, 8)});

        // R10 R11 R12: tiny buffers, both acknowledged before the run
        run_en = 1'b0;
        apply(6'b0_1_11_1_0);
        base0 = 32'h100; base1 = 32'h200; buf_size = 16'd8;
        log_clr = 1'b1;
        buf_ack = 2'b11;
        @(negedge clk);
        log_clr = 1'b0;
        buf_ack = 2'b00;
        @(negedge clk);
        run_en = 1'b1;
        repeat (80) @(negedge clk);
        check("R1 R10 addresses", {nreq, log_addr[0], log_addr[1], log_addr[2], log_addr[3]},
              {32'd5, 32'h100, 32'h104, 32'h200, 32'h204});
        check("R1 R10 fifth address", {128'b0, log_addr[4]}, {128'b0, 32'h100});
        check("R11 done flags", {158'b0, buf_done}, {158'b0, 2'b11});
        check("R12 underrun set", {159'b0, underrun}, {159'b0, 1'b1});
        tick();
        begin
            logic [127:0] e;
            for (int j = 0; j < 8; j++)
                e[16*j +: 16] = exp_at((j < 4 ? 32'h100 : 32'h200) + 2 * (j % 4), 6'b0_1_11_1_0);
            check("R10 slots across switch", {31'b0, frame_ok, slot_data}, {31'b0, 1'b1, e});
        end
        buf_ack = 2'b01;
        @(negedge clk);
        buf_ack = 2'b00;
        check("R11 ack clears", {158'b0, buf_done}, {158'b0, 2'b10});
        check("R12 underrun sticky", {159'b0, underrun}, {159'b0, 1'b1});
        run_en = 1'b0;
        @(negedge clk);
        check("R12 underrun cleared", {159'b0, underrun}, {159'b0, 1'b0});

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule